// File: doc/BRIEF.md
# Multichannel Time-Slot Unpacker

This block turns a channelized stream back into one sample per channel. Samples from several channels arrive interleaved in time over one or more data wires. Each cycle carries one shared valid bit, an 8-bit slot index that counts the position within the repeating frame, and the data wires. The block is given the channel count and the frame period as parameters. From these it works out how many wires are in use and which channel each wire carries at each slot. It writes every meaningful lane into that channel's holding register and leaves out lanes that carry no channel in that slot.

When the sample in the highest occupied slot has been captured, the block publishes the assembled vector, which holds one sample per channel, and pulses a frame-complete strobe. The published vector then stays unchanged until the next strobe. A valid cycle with a slot index the frame cannot contain is dropped, and it sets a sticky error flag.

Top module: `ts_unpacker`

## Requirements
- R1: A cycle with `in_valid` low changes nothing, whatever its slot index and data. No channel register is written, no strobe follows, and the error flag is not set.
- R2: The wire count is NW = ceil(NUM_CH / PERIOD). Channels are divided evenly with the lower wires filled first: wire w carries floor(NUM_CH/NW) channels, plus one more when w < NUM_CH mod NW. The first channel of wire w is the sum of the counts of all lower wires.
- R3: On a valid cycle with slot index s, the lane of wire w, found in `in_data` bits [w*DW +: DW], is written to channel (first channel of wire w) + s. Channel c is published in `out_samples` bits [c*DW +: DW].
- R4: On a valid cycle, a lane whose slot index is at or above its own wire's channel count is not written. For example, with 5 channels in a 3-cycle frame, wire 1 at slot 2 is never written.
- R5: `frame_done` is high for exactly the one cycle after a valid cycle whose slot index equals NS-1, where NS is the channel count of wire 0. In that same cycle `out_samples` shows every channel's most recently captured sample, including the lanes captured in that final cycle.
- R6: A valid cycle whose slot index is NS or above writes no channel and does not raise `frame_done`.
- R7: `proto_err` goes high in the cycle after a valid cycle whose slot index is NS or above. It stays high until reset.
- R8: `out_samples` changes only in cycles where `frame_done` is high.
- R9: After reset, `out_samples`, every channel register, `frame_done` and `proto_err` are all zero.
- R10: When PERIOD is 1, each wire carries one channel at slot 0. Every valid slot-0 cycle completes a frame, and any nonzero slot index is an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Shared valid bit for all wires |
| in_slot | input | 8 | Slot index within the frame |
| in_data | input | NW*DW | Packed data wires; wire w is in bits [w*DW +: DW] |
| out_samples | output | NUM_CH*DW | Published samples; channel c is in bits [c*DW +: DW] |
| frame_done | output | 1 | One-cycle frame-complete strobe |
| proto_err | output | 1 | Sticky flag for out-of-range slot indices |

## Verification
The bench builds two instances. The first uses 5 channels in a 3-cycle frame. It has unequal wire loads (three channels and two), so the empty lane on wire 1 at slot 2 is exercised, along with slot indices above the frame and frames whose slots arrive out of order. The second uses 4 channels with a period of 1. This covers the case where each wire carries a single channel and every valid cycle completes a frame.

// File: rtl/ts_unpack_pkg.sv
package ts_unpack_pkg;

  // Number of data wires needed to carry nch channels in a per-cycle frame.
  function automatic int f_wires(input int nch, input int per);
    return (nch + per - 1) / per;
  endfunction

  // Channels carried by wire w (lower wires take the remainder).
  function automatic int f_alloc(input int nch, input int per, input int w);
    int nw;
    nw = f_wires(nch, per);
    return (nch / nw) + ((w < (nch % nw)) ? 1 : 0);
  endfunction

  // First channel carried by wire w.
  function automatic int f_first(input int nch, input int per, input int w);
    int nw;
    int rem;
    nw  = f_wires(nch, per);
    rem = nch % nw;
    return w * (nch / nw) + ((w < rem) ? w : rem);
  endfunction

  // Occupied slots in a frame (allocation of wire 0).
  function automatic int f_slots(input int nch, input int per);
    return f_alloc(nch, per, 0);
  endfunction

  // Wire that carries channel c.
  function automatic int f_wire_of(input int nch, input int per, input int c);
    int res;
    res = 0;
    for (int w = 0; w < f_wires(nch, per); w++) begin
      if (c >= f_first(nch, per, w)) res = w;
    end
    return res;
  endfunction

  // Slot in which channel c appears.
  function automatic int f_slot_of(input int nch, input int per, input int c);
    return c - f_first(nch, per, f_wire_of(nch, per, c));
  endfunction

endpackage

// File: rtl/ts_slot_decoder.sv
module ts_slot_decoder
  import ts_unpack_pkg::*;
#(
  parameter int NUM_CH = 5,
  parameter int PERIOD = 3,
  localparam int NW = f_wires(NUM_CH, PERIOD)
) (
  input  logic          in_valid,
  input  logic [7:0]    in_slot,
  output logic [NW-1:0] lane_en,
  output logic          bad_cycle,
  output logic          last_cycle
);

  localparam int NS = f_slots(NUM_CH, PERIOD);

  // Per-wire lane qualification against that wire's own allocation.
  for (genvar w = 0; w < NW; w++) begin : g_lane
    localparam int ALLOC = f_alloc(NUM_CH, PERIOD, w);
    always_comb lane_en[w] = in_valid && (int'(in_slot) < ALLOC);
  end

  always_comb begin
    bad_cycle  = in_valid && (int'(in_slot) >= NS);
    last_cycle = in_valid && (int'(in_slot) == NS - 1);
  end

endmodule

// File: rtl/ts_chan_store.sv
module ts_chan_store
  import ts_unpack_pkg::*;
#(
  parameter int NUM_CH = 5,
  parameter int PERIOD = 3,
  parameter int DW     = 8,
  localparam int NW = f_wires(NUM_CH, PERIOD)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 bad_cycle,
  input  logic [NW-1:0]        lane_en,
  input  logic [7:0]           in_slot,
  input  logic [NW*DW-1:0]     in_data,
  output logic [NUM_CH*DW-1:0] merged,
  output logic [NUM_CH*DW-1:0] shadow
);

  logic [NUM_CH-1:0] chan_we;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    localparam int WIRE = f_wire_of(NUM_CH, PERIOD, c);
    localparam int SLOT = f_slot_of(NUM_CH, PERIOD, c);

    logic [DW-1:0] lane;
    always_comb begin
      lane       = in_data[WIRE*DW +: DW];
      chan_we[c] = lane_en[WIRE] && (int'(in_slot) == SLOT);
      merged[c*DW +: DW] = chan_we[c] ? lane : shadow[c*DW +: DW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          shadow[c*DW +: DW] <= '0;
      else if (chan_we[c]) shadow[c*DW +: DW] <= lane;
    end
  end

  // At most one channel of a wire can be written in a cycle.
  for (genvar w = 0; w < NW; w++) begin : g_wchk
    localparam int FIRST = f_first(NUM_CH, PERIOD, w);
    localparam int ALLOC = f_alloc(NUM_CH, PERIOD, w);
    AST_LANE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(chan_we[FIRST +: ALLOC])); // R3
  end

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(shadow)); // R1
  AST_BAD_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cycle |=> $stable(shadow)); // R6

endmodule

// File: rtl/ts_frame_publish.sv
module ts_frame_publish #(
  parameter int NUM_CH = 5,
  parameter int DW     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 last_cycle,
  input  logic [NUM_CH*DW-1:0] merged,
  output logic [NUM_CH*DW-1:0] out_samples,
  output logic                 frame_done
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_samples <= '0;
      frame_done  <= 1'b0;
    end else begin
      frame_done <= last_cycle;
      if (last_cycle) out_samples <= merged;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |-> $stable(out_samples)); // R8

endmodule

// File: rtl/ts_err_flag.sv
module ts_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic bad_cycle,
  output logic proto_err
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         proto_err <= 1'b0;
    else if (bad_cycle) proto_err <= 1'b1;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err); // R7
  AST_ERR_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cycle |=> proto_err); // R7

endmodule

// File: rtl/ts_unpacker.sv
module ts_unpacker
  import ts_unpack_pkg::*;
#(
  parameter int NUM_CH = 5,
  parameter int PERIOD = 3,
  parameter int DW     = 8,
  localparam int NW = f_wires(NUM_CH, PERIOD)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [7:0]           in_slot,
  input  logic [NW*DW-1:0]     in_data,
  output logic [NUM_CH*DW-1:0] out_samples,
  output logic                 frame_done,
  output logic                 proto_err
);

  localparam int NS = f_slots(NUM_CH, PERIOD);

  logic [NW-1:0]        lane_en;
  logic                 bad_cycle;
  logic                 last_cycle;
  logic [NUM_CH*DW-1:0] merged;
  logic [NUM_CH*DW-1:0] shadow;

  ts_slot_decoder #(.NUM_CH(NUM_CH), .PERIOD(PERIOD)) u_dec (
    .in_valid   (in_valid),
    .in_slot    (in_slot),
    .lane_en    (lane_en),
    .bad_cycle  (bad_cycle),
    .last_cycle (last_cycle)
  );

  ts_chan_store #(.NUM_CH(NUM_CH), .PERIOD(PERIOD), .DW(DW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .bad_cycle (bad_cycle),
    .lane_en   (lane_en),
    .in_slot   (in_slot),
    .in_data   (in_data),
    .merged    (merged),
    .shadow    (shadow)
  );

  ts_frame_publish #(.NUM_CH(NUM_CH), .DW(DW)) u_pub (
    .clk         (clk),
    .rst_n       (rst_n),
    .last_cycle  (last_cycle),
    .merged      (merged),
    .out_samples (out_samples),
    .frame_done  (frame_done)
  );

  ts_err_flag u_err (
    .clk       (clk),
    .rst_n     (rst_n),
    .bad_cycle (bad_cycle),
    .proto_err (proto_err)
  );

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(in_valid && (int'(in_slot) == NS - 1))); // R5
  AST_LAST_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (int'(in_slot) == NS - 1)) |=> frame_done); // R5

endmodule

// File: tb/test_ts_unpacker.sv
module test_ts_unpacker;

  localparam int NC  = 5;
  localparam int PER = 3;
  localparam int W   = 8;
  localparam int NW  = (NC + PER - 1) / PER;
  localparam int NS  = (NC + NW - 1) / NW;
  localparam int NC1 = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic            in_valid = 1'b0;
  logic [7:0]      in_slot = '0;
  logic [NW*W-1:0] in_data = '0;
  logic [NC*W-1:0] out_samples;
  logic            frame_done, proto_err;

  logic             p_valid = 1'b0;
  logic [7:0]       p_slot = '0;
  logic [NC1*W-1:0] p_data = '0;
  logic [NC1*W-1:0] p_out;
  logic             p_done, p_err;

  ts_unpacker #(.NUM_CH(NC), .PERIOD(PER), .DW(W)) i_ts_unpacker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_slot(in_slot),
    .in_data(in_data), .out_samples(out_samples), .frame_done(frame_done),
    .proto_err(proto_err));

  ts_unpacker #(.NUM_CH(NC1), .PERIOD(1), .DW(W)) i_ts_unpacker_p1 (
    .clk(clk), .rst_n(rst_n), .in_valid(p_valid), .in_slot(p_slot),
    .in_data(p_data), .out_samples(p_out), .frame_done(p_done),
    .proto_err(p_err));

  int n_chk = 0;
  int n_fail = 0;
  logic [NC*W-1:0] exp_sh = '0;
  logic [NC*W-1:0] prev_out = '0;
  logic            exp_err = 1'b0;
  logic [NC*W-1:0] sb_q[$];

  // Bench-side allocation: wire w holds ceil((NC-w)/NW) channels.
  function automatic int b_alloc(input int w);
    return (NC - w + NW - 1) / NW;
  endfunction
  function automatic int b_first(input int w);
    int s;
    s = 0;
    for (int k = 0; k < w; k++) s += b_alloc(k);
    return s;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: one cycle on the main instance, with the scoreboard model.
  task automatic drive(input bit v, input int s, input logic [NW*W-1:0] d);
    @(negedge clk);
    in_valid = v;
    in_slot  = s[7:0];
    in_data  = d;
    if (v && s < NS) begin
      for (int w = 0; w < NW; w++)
        if (s < b_alloc(w)) exp_sh[(b_first(w) + s)*W +: W] = d[w*W +: W];
    end
    if (v && s >= NS) exp_err = 1'b1;
    if (v && s == NS - 1) sb_q.push_back(exp_sh);
  endtask

  task automatic idle(input int s);
    drive(1'b0, s, {NW{8'hEE}} ^ NW*W'(s));
  endtask

  function automatic logic [NW*W-1:0] pat(input int f, input int s);
    logic [NW*W-1:0] d;
    for (int w = 0; w < NW; w++) d[w*W +: W] = 8'(f * 29 + w * 16 + s * 3 + 1);
    return d;
  endfunction

  task automatic frame(input int f, input bit gaps);
    for (int s = 0; s < NS; s++) begin
      drive(1'b1, s, pat(f, s));
      if (gaps) idle(s + 1);
    end
  endtask

  // Monitor: pops expected vectors on strobes, checks hold between them.
  always @(negedge clk) begin
    if (!rst_n) prev_out = '0;
    else begin
      if (frame_done) begin
        if (sb_q.size() == 0) check("R5 unexpected strobe", 64'(frame_done), 64'd0);
        else check("R3 R4 R5 frame vector", 64'(out_samples), 64'(sb_q.pop_front()));
      end else begin
        check("R8 hold", 64'(out_samples), 64'(prev_out));
      end
      prev_out = out_samples;
    end
  end

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset out", 64'(out_samples), 64'd0);
    check("R9 reset done", 64'(frame_done), 64'd0);
    check("R9 reset err", 64'(proto_err), 64'd0);
    check("R9 reset p1 out", 64'(p_out), 64'd0);
    rst_n = 1'b1;
    idle(2);

    // R2 R3 R4: frames with gaps; wire 1 carries garbage at slot 2
    frame(1, 1'b1);
    frame(2, 1'b1);
    // R1: invalid cycles with slot indices and data mid-frame
    drive(1'b1, 0, pat(3, 0));
    idle(2); idle(1);
    drive(1'b1, 1, pat(3, 1));
    idle(2);
    drive(1'b1, 2, pat(3, 2));
    idle(0);
    check("R1 no err from invalid", 64'(proto_err), 64'd0);
    // Out-of-order slots: last slot first completes with older samples
    drive(1'b1, 2, pat(4, 2));
    drive(1'b1, 0, pat(4, 0));
    drive(1'b1, 1, pat(4, 1));
    drive(1'b1, 2, pat(5, 2));
    // Back-to-back frames
    frame(6, 1'b0);
    frame(7, 1'b0);
    idle(0);
    check("R7 err still low", 64'(proto_err), 64'd0);
    // R6 R7: out-of-range slot indices
    drive(1'b1, NS, pat(8, 0));
    idle(0);
    check("R7 err raised", 64'(proto_err), 64'(exp_err));
    drive(1'b1, 200, pat(9, 0));
    drive(1'b1, 255, pat(9, 1));
    idle(1);
    drive(1'b1, 2, pat(10, 2));
    idle(0);
    check("R6 bad slots discarded", 64'(proto_err), 64'd1);
    frame(11, 1'b1);
    repeat (4) idle(3);
    check("R7 err sticky", 64'(proto_err), 64'd1);

    // Reset clears everything
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    exp_sh = '0;
    exp_err = 1'b0;
    @(negedge clk);
    check("R7 R9 err after reset", 64'(proto_err), 64'd0);
    check("R9 out after reset", 64'(out_samples), 64'd0);
    rst_n = 1'b1;
    drive(1'b1, 2, pat(12, 2));
    idle(0);
    frame(13, 1'b1);

    // R10: period 1, each wire is one channel at slot 0
    @(negedge clk);
    p_valid = 1'b1; p_slot = 8'd0; p_data = 32'hA1B2C3D4;
    @(negedge clk);
    check("R10 p1 strobe", 64'(p_done), 64'd1);
    check("R10 p1 vector", 64'(p_out), 64'hA1B2C3D4);
    p_data = 32'h11223344;
    @(negedge clk);
    check("R10 p1 back-to-back", 64'(p_out), 64'h11223344);
    p_valid = 1'b0; p_data = 32'hFFFFFFFF;
    @(negedge clk);
    @(negedge clk);
    check("R10 p1 no strobe when idle", 64'(p_done), 64'd0);
    check("R10 p1 hold", 64'(p_out), 64'h11223344);
    p_valid = 1'b1; p_slot = 8'd1; p_data = 32'h55555555;
    @(negedge clk);
    p_valid = 1'b0;
    @(negedge clk);
    check("R10 p1 nonzero slot err", 64'(p_err), 64'd1);
    check("R10 p1 nonzero slot no write", 64'(p_out), 64'h11223344);

    repeat (4) idle(0);
    check("R5 all frames strobed", 64'(sb_q.size()), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule